// File: doc/BRIEF.md
# I3C Target In-Band Interrupt Requester

This block is the target-side sequencer that raises an in-band interrupt on a two-wire I3C bus. It watches the sampled SCL and SDA levels and touches the bus only through an open-drain pull-low enable for SDA. When firmware asks for an interrupt, the block holds the request pending until two things are true: interrupts are enabled on the bus, and it has an address to send. It then either creates its own start condition once the bus has been idle long enough, or joins a start that another device has already made. After the start it arbitrates its address with R/W = 1 and reads the acknowledge bit.

The interrupt-enable flag is driven by two pulses from an already decoded enable-events or disable-events command. A static-address mode bit lets the block use its static address while no dynamic address has been assigned. A dynamic address always takes precedence over the static one. Each attempt ends with exactly one one-cycle outcome pulse: done, NACK, arbitration lost, private write to this target, or timeout. There is no data stream at the edge of this block, so no valid/ready handshake applies, and every control and status pin is a plain level or a pulse.

Top module: `i3c_ibi_requester`

## Requirements
- R1: After reset the interrupt-enable flag `irq_en_o` is 0. A pulse on `evt_enable_i` sets it, and a pulse on `evt_disable_i` clears it. When both pulses arrive in the same cycle, the flag ends up 0.
- R2: A pulse on `req_set_i` sets `req_pending_o`. While `irq_en_o` is 0 the request stays pending and SDA is never pulled. Once the flag becomes 1 the attempt begins without a new request.
- R3: When `dyn_valid_i` is 1, the header carries `dyn_addr_i`, whatever `static_mode_i` is. When `dyn_valid_i` is 0 and `static_mode_i` is 1, it carries `static_addr_i`. When both are 0, no attempt is made and the request stays pending.
- R4: For an attempt it starts itself, the block pulls SDA low only after SCL and SDA have both read high for IDLE_CYCLES consecutive clock cycles (within 3 cycles after that). Any low level on either line restarts the count.
- R5: If another device makes a start (SDA falls while SCL is high) before the bus has been idle long enough, the block does not pull SDA during that start. It joins the header that follows.
- R6: The header is the 7-bit address, MSB first, followed by a 1 (read). The block changes its SDA drive only while SCL is low. A 0 bit pulls SDA and a 1 bit releases it.
- R7: If the block releases SDA for one of the seven address bits but reads 0 on the SCL rising edge, it pulses `arb_lost_o` and stops driving for the rest of the header. The request stays pending.
- R8: After it wins the header, the block releases SDA for the ninth bit. A 0 read there pulses `done_o` and clears the pending request.
- R9: A 1 read in the ninth bit pulses `nack_o` and keeps the request pending. At most one outcome pulse is high in any cycle.
- R10: If every address bit matches but SDA reads 0 on the R/W bit (the controller writing to this target), the block pulses `priv_wr_o` instead of `arb_lost_o`.
- R11: If SCL does not fall within `timeout_i` cycles after the block pulls SDA for its own start, the block releases SDA, pulses `timeout_o` and clears the pending request.
- R12: Arbitration is bitwise wired-AND, so a 0 beats a 1. Against another device's address, the numerically lower address wins the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| req_set_i | input | 1 | Pulse: request an in-band interrupt |
| evt_enable_i | input | 1 | Pulse: enable-events command decoded |
| evt_disable_i | input | 1 | Pulse: disable-events command decoded |
| static_mode_i | input | 1 | Allow the static address when no dynamic one exists |
| static_addr_i | input | AW | Static address |
| dyn_addr_i | input | AW | Dynamic address |
| dyn_valid_i | input | 1 | Dynamic address has been assigned |
| timeout_i | input | TOW | Start-answer timeout, in clock cycles |
| irq_en_o | output | 1 | Interrupt-enable flag |
| req_pending_o | output | 1 | A request is outstanding |
| done_o | output | 1 | Pulse: request acknowledged |
| nack_o | output | 1 | Pulse: request not acknowledged |
| arb_lost_o | output | 1 | Pulse: arbitration lost in the address |
| priv_wr_o | output | 1 | Pulse: lost on R/W to a write to this target |
| timeout_o | output | 1 | Pulse: start not answered in time |

## Verification
The hardest states to reach from the ports are losing on the R/W bit after the block's own address has matched, and joining a start made by someone else before the idle count expires. Both depend on a second party driving SDA in a precise phase of SCL. The bench therefore models the bus as a wired-AND of the design's pull, a controller and a second open-drain target that drops out when it loses. It places the foreign start a few cycles after SCL rises, well short of the idle threshold, and has the controller send this target's own address with a 0 R/W bit.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_JOIN,
    ST_HDR,
    ST_ACK
  } ibi_state_t;
endpackage

// File: rtl/ibi_bus_watch.sv
module ibi_bus_watch #(
  parameter int IDLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic avail_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(IDLE_CYCLES);

  logic scl_q, sda_q;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      hi_cnt_q <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (scl_i && sda_i) begin
        if (hi_cnt_q != CMAX) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
        hi_cnt_q <= '0;
      end
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign avail_o    = (hi_cnt_q == CMAX);

  AST_AVAIL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> $past(scl_i && sda_i)); // R4
endmodule

// File: rtl/ibi_hdr_arb.sv
module ibi_hdr_arb #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          active_i,
  input  logic          scl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic [AW-1:0] addr_i,
  output logic          drive_o,
  output logic          lost_o,
  output logic          lost_rw_o,
  output logic          last_o
);
  localparam int HW = AW + 1;
  localparam int IW = $clog2(HW);
  localparam logic [IW-1:0] LAST = IW'(HW - 1);

  logic [HW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic          cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= {addr_i, 1'b1};
      idx_q <= '0;
    end else if (active_i && scl_fall_i && idx_q != LAST) begin
      sh_q  <= {sh_q[HW-2:0], 1'b1};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit   = sh_q[HW-1];
  assign drive_o   = active_i & ~cur_bit;
  assign lost_o    = active_i & scl_rise_i & cur_bit & ~sda_i;
  assign lost_rw_o = lost_o & (idx_q == LAST);
  assign last_o    = active_i & scl_fall_i & (idx_q == LAST);

  AST_DRIVE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i) && scl_i && $past(scl_i)) |-> $stable(drive_o)); // R6
endmodule

// File: rtl/i3c_ibi_requester.sv
module i3c_ibi_requester
  import ibi_pkg::*;
#(
  parameter int AW          = 7,
  parameter int IDLE_CYCLES = 16,
  parameter int TOW         = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_pull_o,
  input  logic           req_set_i,
  input  logic           evt_enable_i,
  input  logic           evt_disable_i,
  input  logic           static_mode_i,
  input  logic [AW-1:0]  static_addr_i,
  input  logic [AW-1:0]  dyn_addr_i,
  input  logic           dyn_valid_i,
  input  logic [TOW-1:0] timeout_i,
  output logic           irq_en_o,
  output logic           req_pending_o,
  output logic           done_o,
  output logic           nack_o,
  output logic           arb_lost_o,
  output logic           priv_wr_o,
  output logic           timeout_o
);
  logic scl_rise, scl_fall, start_seen, bus_avail;

  ibi_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_seen),
    .avail_o    (bus_avail)
  );

  ibi_state_t     state_q, state_d;
  logic           irq_en_q, pending_q;
  logic [TOW-1:0] tcnt_q;
  logic           addr_ok;
  logic [AW-1:0]  addr_sel;
  logic           expire;
  logic           hdr_load, hdr_active, hdr_drive, hdr_lost, hdr_lost_rw, hdr_last;
  logic           set_done, set_nack, set_arb, set_pw, set_to;

  assign addr_ok  = dyn_valid_i | static_mode_i;
  assign addr_sel = dyn_valid_i ? dyn_addr_i : static_addr_i;
  assign expire   = ({1'b0, tcnt_q} + {{TOW{1'b0}}, 1'b1}) >= {1'b0, timeout_i};

  assign hdr_active = (state_q == ST_HDR);
  assign hdr_load   = (state_d == ST_HDR) && (state_q != ST_HDR);

  ibi_hdr_arb #(.AW(AW)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (hdr_load),
    .active_i   (hdr_active),
    .scl_i      (scl_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_i),
    .addr_i     (addr_sel),
    .drive_o    (hdr_drive),
    .lost_o     (hdr_lost),
    .lost_rw_o  (hdr_lost_rw),
    .last_o     (hdr_last)
  );

  always_comb begin
    state_d  = state_q;
    set_done = 1'b0;
    set_nack = 1'b0;
    set_arb  = 1'b0;
    set_pw   = 1'b0;
    set_to   = 1'b0;
    case (state_q)
      ST_IDLE: if (pending_q && irq_en_q && addr_ok) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!(pending_q && irq_en_q && addr_ok)) state_d = ST_IDLE;
        else if (start_seen)                     state_d = ST_JOIN;
        else if (bus_avail)                      state_d = ST_START;
      end
      ST_JOIN: if (scl_fall) state_d = ST_HDR;
      ST_START: begin
        if (scl_fall) state_d = ST_HDR;
        else if (expire) begin
          state_d = ST_IDLE;
          set_to  = 1'b1;
        end
      end
      ST_HDR: begin
        if (hdr_lost) begin
          state_d = ST_IDLE;
          set_pw  = hdr_lost_rw;
          set_arb = ~hdr_lost_rw;
        end else if (hdr_last) begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: if (scl_rise) begin
        state_d  = ST_IDLE;
        set_done = ~sda_i;
        set_nack = sda_i;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      irq_en_q   <= 1'b0;
      pending_q  <= 1'b0;
      tcnt_q     <= '0;
      done_o     <= 1'b0;
      nack_o     <= 1'b0;
      arb_lost_o <= 1'b0;
      priv_wr_o  <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt_disable_i)     irq_en_q <= 1'b0;
      else if (evt_enable_i) irq_en_q <= 1'b1;
      if (req_set_i)                pending_q <= 1'b1;
      else if (set_done || set_to)  pending_q <= 1'b0;
      tcnt_q     <= (state_q == ST_START) ? tcnt_q + 1'b1 : '0;
      done_o     <= set_done;
      nack_o     <= set_nack;
      arb_lost_o <= set_arb;
      priv_wr_o  <= set_pw;
      timeout_o  <= set_to;
    end
  end

  assign sda_pull_o    = (state_q == ST_START) | hdr_drive;
  assign irq_en_o      = irq_en_q;
  assign req_pending_o = pending_q;

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_disable_i) |-> !irq_en_o); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, nack_o, arb_lost_o, priv_wr_o, timeout_o})); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(req_set_i)) |-> !req_pending_o); // R8
  AST_NACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> req_pending_o); // R9
  AST_ARB_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> (req_pending_o && !sda_pull_o)); // R7
  AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !sda_pull_o); // R11
endmodule

// File: tb/i3c_ibi_requester_test.sv
module i3c_ibi_requester_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_CYC   = 16;
  localparam int TO_CYC     = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_ctrl = 1'b1, other_pull = 1'b0, other_lost = 1'b0;
  logic req_set = 1'b0, evt_en = 1'b0, evt_dis = 1'b0;
  logic static_mode = 1'b0, dyn_valid = 1'b0;
  logic [6:0] static_addr = 7'h33, dyn_addr = 7'h2A;
  logic sda_pull, irq_en, pending, done_p, nack_p, arb_p, pw_p, to_p;
  wire  sda_line = sda_ctrl & ~other_pull & ~sda_pull;

  int pull_cnt = 0, done_cnt = 0, nack_cnt = 0, arb_cnt = 0, pw_cnt = 0, to_cnt = 0;
  int checks = 0, errors = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i3c_ibi_requester uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .req_set_i(req_set), .evt_enable_i(evt_en), .evt_disable_i(evt_dis),
    .static_mode_i(static_mode), .static_addr_i(static_addr), .dyn_addr_i(dyn_addr),
    .dyn_valid_i(dyn_valid), .timeout_i(16'(TO_CYC)), .irq_en_o(irq_en),
    .req_pending_o(pending), .done_o(done_p), .nack_o(nack_p), .arb_lost_o(arb_p),
    .priv_wr_o(pw_p), .timeout_o(to_p)
  );

  always @(posedge clk) begin
    if (sda_pull) pull_cnt++;
    if (done_p)   done_cnt++;
    if (nack_p)   nack_cnt++;
    if (arb_p)    arb_cnt++;
    if (pw_p)     pw_cnt++;
    if (to_p)     to_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; scl = 1; sda_ctrl = 1; other_pull = 0; other_lost = 0;
    req_set = 0; evt_en = 0; evt_dis = 0; static_mode = 0; dyn_valid = 1;
    dyn_addr = 7'h2A; static_addr = 7'h33;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic pulse_en();   evt_en = 1;  cyc(1); evt_en = 0;  endtask
  task automatic pulse_dis();  evt_dis = 1; cyc(1); evt_dis = 0; endtask
  task automatic request();    req_set = 1; cyc(1); req_set = 0; endtask

  task automatic wait_pull(output int n);
    n = 0;
    while (!sda_pull && n < 300) begin cyc(1); n++; end
  endtask

  task automatic hbit(input bit ctrl, input bit other_on, input bit obit, output bit line);
    scl = 0; cyc(2);
    sda_ctrl = ctrl;
    other_pull = other_on & ~obit & ~other_lost;
    cyc(2);
    scl = 1; cyc(1);
    line = sda_line;
    if (other_on && obit && !line) other_lost = 1;
    cyc(3);
  endtask

  task automatic header(input logic [6:0] caddr, input bit crw, input bit other_on,
                        input logic [6:0] oaddr, output logic [7:0] seen);
    for (int i = 0; i < 8; i++) begin
      bit cb, ob, ln;
      cb = (i < 7) ? caddr[6-i] : crw;
      ob = (i < 7) ? oaddr[6-i] : 1'b1;
      hbit(cb, other_on, ob, ln);
      seen[7-i] = ln;
    end
    other_pull = 0;
  endtask

  task automatic ack_bit(input bit v);
    bit ln;
    hbit(v, 1'b0, 1'b0, ln);
  endtask

  task automatic t_reset();
    do_reset();
    check(!sda_pull && !irq_en && !pending, "reset R1 outputs idle", {sda_pull, irq_en, pending}, 0);
    check(!(done_p | nack_p | arb_p | pw_p | to_p), "reset outcome pulses", 1, 0);
  endtask

  task automatic t_enable();
    do_reset();
    pulse_en();  check(irq_en == 1, "R1 enable pulse", irq_en, 1);
    pulse_dis(); check(irq_en == 0, "R1 disable pulse", irq_en, 0);
    pulse_en();
    evt_en = 1; evt_dis = 1; cyc(1); evt_en = 0; evt_dis = 0;
    check(irq_en == 0, "R1 simultaneous pulses", irq_en, 0);
  endtask

  task automatic t_standard();
    int p0, n, d0;
    logic [7:0] seen;
    do_reset();
    static_mode = 1;
    p0 = pull_cnt;
    request();
    cyc(IDLE_CYC * 3);
    check(pull_cnt == p0, "R2 no pull while disabled", pull_cnt - p0, 0);
    check(pending == 1, "R2 pending held", pending, 1);
    pulse_en();
    wait_pull(n);
    check(n <= 4, "R2 attempt starts once enabled", n, 4);
    d0 = done_cnt;
    header(7'h7F, 1'b1, 1'b0, 7'h00, seen);
    check(seen == {7'h2A, 1'b1}, "R6 R3 header dynamic address read", seen, {7'h2A, 1'b1});
    ack_bit(1'b0);
    check(done_cnt - d0 == 1, "R8 done pulse", done_cnt - d0, 1);
    check(pending == 0, "R8 pending cleared", pending, 0);
  endtask

  task automatic t_idle_timeout();
    int p0, n, t0;
    do_reset();
    scl = 0;
    pulse_en(); request(); cyc(5);
    scl = 1; cyc(IDLE_CYC - 4);
    scl = 0; cyc(1); scl = 1;
    wait_pull(n);
    check(n >= IDLE_CYC && n <= IDLE_CYC + 3, "R4 idle count restarted", n, IDLE_CYC + 1);
    t0 = to_cnt;
    cyc(TO_CYC + 5);
    check(to_cnt - t0 == 1, "R11 timeout pulse", to_cnt - t0, 1);
    check(sda_pull == 0 && pending == 0, "R11 released and cleared", {sda_pull, pending}, 0);
    p0 = pull_cnt;
    cyc(IDLE_CYC * 3);
    check(pull_cnt == p0, "R11 no retry after timeout", pull_cnt - p0, 0);
  endtask

  task automatic t_nack();
    int n, k0, d0;
    logic [7:0] seen;
    do_reset();
    pulse_en(); request();
    wait_pull(n);
    k0 = nack_cnt; d0 = done_cnt;
    header(7'h7F, 1'b1, 1'b0, 7'h00, seen);
    ack_bit(1'b1);
    check(nack_cnt - k0 == 1 && done_cnt == d0, "R9 nack pulse only", nack_cnt - k0, 1);
    check(pending == 1, "R9 pending kept", pending, 1);
  endtask

  task automatic t_arb_lost();
    int n, a0, w0;
    logic [7:0] seen;
    do_reset();
    pulse_en(); request();
    wait_pull(n);
    a0 = arb_cnt; w0 = pw_cnt;
    header(7'h7F, 1'b1, 1'b1, 7'h21, seen);
    check(seen == {7'h21, 1'b1}, "R7 R12 lower address wins, released", seen, {7'h21, 1'b1});
    check(arb_cnt - a0 == 1 && pw_cnt == w0, "R7 arb lost pulse", arb_cnt - a0, 1);
    check(pending == 1, "R7 pending kept", pending, 1);
  endtask

  task automatic t_priv_write();
    int n, a0, w0;
    logic [7:0] seen;
    do_reset();
    pulse_en(); request();
    wait_pull(n);
    a0 = arb_cnt; w0 = pw_cnt;
    header(7'h2A, 1'b0, 1'b0, 7'h00, seen);
    check(seen == {7'h2A, 1'b0}, "R10 write header seen", seen, {7'h2A, 1'b0});
    check(pw_cnt - w0 == 1, "R10 private write pulse", pw_cnt - w0, 1);
    check(arb_cnt == a0, "R10 not reported as arb loss", arb_cnt - a0, 0);
  endtask

  task automatic t_passive();
    int p0, d0;
    logic [7:0] seen;
    do_reset();
    scl = 0;
    pulse_en(); request(); cyc(4);
    scl = 1; cyc(3);
    p0 = pull_cnt;
    sda_ctrl = 0; cyc(3);
    check(pull_cnt == p0, "R5 no own start when joining", pull_cnt - p0, 0);
    d0 = done_cnt;
    header(7'h7F, 1'b1, 1'b1, 7'h55, seen);
    check(seen == {7'h2A, 1'b1}, "R5 R12 joined header won", seen, {7'h2A, 1'b1});
    ack_bit(1'b0);
    check(done_cnt - d0 == 1, "R5 done after passive join", done_cnt - d0, 1);
  endtask

  task automatic t_addr_select();
    int p0, n;
    logic [7:0] seen;
    do_reset();
    dyn_valid = 0; static_mode = 0;
    p0 = pull_cnt;
    pulse_en(); request();
    cyc(IDLE_CYC * 3);
    check(pull_cnt == p0 && pending == 1, "R3 no address, no attempt", pull_cnt - p0, 0);
    static_mode = 1;
    wait_pull(n);
    check(n <= 4, "R3 static mode starts attempt", n, 4);
    header(7'h7F, 1'b1, 1'b0, 7'h00, seen);
    check(seen == {7'h33, 1'b1}, "R3 static address sent", seen, {7'h33, 1'b1});
    ack_bit(1'b0);
  endtask

  initial begin
    cyc(150000);
    check(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_standard();
    t_idle_timeout();
    t_nack();
    t_arb_lost();
    t_priv_write();
    t_passive();
    t_addr_select();
    report();
    $finish;
  end
endmodule